// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is the transmit half of a classic bus-programmed serial port. A host on an 8-bit microprocessor bus programs it and feeds it bytes. The bus has an active-low select, active-low read and write strobes, a control/data line and a shared tristate data bus. After a reset, the first control write sets the character format. Each later control write is a command. Data writes load a one-byte holding buffer. A status read returns ready, empty and data-set-ready flags.

Each held byte moves into a shift register and leaves on TXD as a start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. Every bit lasts one period of an external transmit clock. Bits change only on the falling edges of that clock. A byte is only sent while the active-low clear-to-send input is low and the command has enabled the transmitter. If a second byte is waiting when a character finishes, the two frames run back to back with no idle time between them.

Top module: `async_tx_port`

## Requirements
- R1: After reset, TXD is 1, txempty is 1, txrdy is 0, and the next control write (cd=1) is taken as the format byte.
- R2: Once the format byte is written, every further control write is a command. Command bit 0 enables the transmitter. Command bit 6 clears the enable and makes the next control write a format byte again.
- R3: While cs_n=0, rd_n=0 and cd=1, the block drives the status byte onto dbus: bit 7 = NOT dsr_n, bit 2 = txempty, bit 0 = txrdy, all other bits 0. With dsr_n low and cts_n high, format 0xCD followed by command 0x11 reads back as 0x84. The block drives dbus at no other time.
- R4: The format byte sets the frame. Bits [3:2] give the data length: 00 is 5, 01 is 6, 10 is 7, 11 is 8. Bit 4 enables parity. Bit 5 selects even parity. Bits [7:6] = 01 give one stop bit and any other value gives two. If bits [1:0] are 00, a synchronous mode is requested; that mode is unsupported and the transmitter stays silent.
- R5: A frame is a start bit (0), then the data bits with the LSB first, then the parity bit if enabled, then the stop bits (1). Each bit lasts one transmit-clock period. The start bit begins at the first falling edge of txc_n after the byte is written, when cts_n is low and the transmitter is enabled.
- R6: With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R7: While cts_n is high, a written byte is held and TXD stays 1. The start bit follows at the first falling edge of txc_n after cts_n goes low.
- R8: A byte written while a frame is shifting is held. Its start bit follows the last stop bit directly, with no idle period between them.
- R9: txrdy is 1 exactly when the holding buffer is empty, the transmitter is enabled and cts_n is low. txempty is 1 exactly when the holding buffer and the shift register are both empty.
- R10: While the transmitter is disabled, a written byte is held and not sent. It is sent once a command sets bit 0.
- R11: TXD is 1 whenever no frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| dbus | inout | 8 | Bidirectional data bus |
| txc_n | input | 1 | External transmit bit clock |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low, shown in status |
| txd | output | 1 | Serial output |
| txrdy | output | 1 | Ready to accept a byte |
| txempty | output | 1 | Holding buffer and shifter both empty |

## Verification
The bench sends a table of format and data pairs. The pairs cover 5, 7 and 8 data bits, no parity, odd parity and even parity, and one or two stop bits. The data values include 0x55, 0xAA and 0x33, whose alternating bits would expose a reversed bit order, a shifted frame or a stop bit counted wrongly. The directed cases check that a frame waits for clear-to-send and for the transmit enable, that a byte written during a frame starts with no gap, that a format with the synchronous code stays silent, and that a second control write goes to the command register and not to the format register.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic [1:0] stop_sel;
    logic       par_even;
    logic       par_en;
    logic [1:0] len_sel;
    logic [1:0] clk_sel;
  } fmt_t;

  typedef enum logic {PH_FORMAT = 1'b0, PH_COMMAND = 1'b1} phase_t;
endpackage

// File: rtl/atx_fall_det.sv
module atx_fall_det #(
  parameter int   SYNC    = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic fall
);
  logic level;
  logic prev;

  generate
    if (SYNC == 0) begin : g_direct
      assign level = sig_in;
    end else begin : g_sync
      logic [SYNC-1:0] stages;
      always_ff @(posedge clk) begin
        if (rst) stages <= {SYNC{RST_VAL}};
        else     stages <= SYNC'({stages, sig_in});
      end
      assign level = stages[SYNC-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= level;
  end

  assign fall = prev & ~level;
endmodule

// File: rtl/atx_regs.sv
module atx_regs
  import atx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             cd,
  input  logic             wr_fall,
  input  logic [BUS_W-1:0] din,
  input  logic             dsr_n,
  input  logic             txrdy,
  input  logic             txempty,
  output fmt_t             fmt,
  output logic             tx_en,
  output logic             hold_wr,
  output logic [BUS_W-1:0] dout,
  output logic             doe
);
  phase_t phase;
  logic   ctl_wr;

  assign ctl_wr  = wr_fall & ~cs_n & cd;
  assign hold_wr = wr_fall & ~cs_n & ~cd;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FORMAT;
      fmt   <= '0;
      tx_en <= 1'b0;
    end else if (ctl_wr) begin
      if (phase == PH_FORMAT) begin
        fmt   <= fmt_t'(din);
        phase <= PH_COMMAND;
      end else if (din[6]) begin
        tx_en <= 1'b0;
        phase <= PH_FORMAT;
      end else begin
        tx_en <= din[0];
      end
    end
  end

  // status snapshot, refreshed every cycle
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= {~dsr_n, 4'b0000, txempty, 1'b0, txrdy};
  end

  assign doe = ~cs_n & ~rd_n & cd;
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
  import atx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  fmt_t          fmt,
  input  logic          tx_en,
  input  logic          cts_n,
  input  logic          tick,
  input  logic          hold_wr,
  input  logic [DW-1:0] hold_in,
  output logic          txd,
  output logic          hold_full,
  output logic          shift_idle
);
  localparam int FRAME_W = DW + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DW-1:0]      hold_q;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] payload;
  logic [CNT_W-1:0]   remain;
  logic [CNT_W-1:0]   nbits;
  logic [DW-1:0]      masked;
  logic               busy;
  logic               par_bit;
  logic               can_load;
  int                 len;

  always_comb begin
    len    = 5 + int'(fmt.len_sel);
    masked = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < len) masked[i] = hold_q[i];
    end
    par_bit = fmt.par_even ? ^masked : ~^masked;
    payload = '1;
    for (int i = 0; i < DW; i++) begin
      if (i < len) payload[i] = masked[i];
    end
    if (fmt.par_en) payload[len] = par_bit;
    nbits = CNT_W'(len + (fmt.par_en ? 1 : 0) + ((fmt.stop_sel == 2'b01) ? 1 : 2));
  end

  assign can_load   = hold_full & tx_en & ~cts_n & (|fmt.clk_sel);
  assign shift_idle = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= 1'b1;
      busy      <= 1'b0;
      remain    <= '0;
      shreg     <= '1;
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (tick) begin
        if (busy && remain != '0) begin
          txd    <= shreg[0];
          shreg  <= {1'b1, shreg[FRAME_W-1:1]};
          remain <= remain - 1'b1;
        end else if (can_load) begin
          txd       <= 1'b0;
          shreg     <= payload;
          remain    <= nbits;
          busy      <= 1'b1;
          hold_full <= 1'b0;
        end else begin
          txd  <= 1'b1;
          busy <= 1'b0;
        end
      end
      if (hold_wr) begin
        hold_q    <= hold_in;
        hold_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_tx_port.sv
module async_tx_port
  import atx_pkg::*;
#(
  parameter int TXC_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             cd,
  inout  wire  [BUS_W-1:0] dbus,
  input  logic             txc_n,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             txd,
  output logic             txrdy,
  output logic             txempty
);
  fmt_t             fmt;
  logic             tx_en;
  logic             wr_fall;
  logic             tx_tick;
  logic             hold_wr;
  logic             hold_full;
  logic             shift_idle;
  logic             bus_oe;
  logic [BUS_W-1:0] stat_byte;

  atx_fall_det #(.SYNC(0), .RST_VAL(1'b1)) u_wr_det (
    .clk(clk), .rst(rst), .sig_in(wr_n), .fall(wr_fall)
  );

  atx_fall_det #(.SYNC(TXC_SYNC), .RST_VAL(1'b1)) u_txc_det (
    .clk(clk), .rst(rst), .sig_in(txc_n), .fall(tx_tick)
  );

  atx_regs u_regs (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .cd(cd),
    .wr_fall(wr_fall), .din(dbus), .dsr_n(dsr_n),
    .txrdy(txrdy), .txempty(txempty),
    .fmt(fmt), .tx_en(tx_en), .hold_wr(hold_wr),
    .dout(stat_byte), .doe(bus_oe)
  );

  atx_shifter #(.DW(BUS_W)) u_shift (
    .clk(clk), .rst(rst), .fmt(fmt), .tx_en(tx_en), .cts_n(cts_n),
    .tick(tx_tick), .hold_wr(hold_wr), .hold_in(dbus),
    .txd(txd), .hold_full(hold_full), .shift_idle(shift_idle)
  );

  assign txrdy   = ~hold_full & tx_en & ~cts_n;
  assign txempty = ~hold_full & shift_idle;
  assign dbus    = bus_oe ? stat_byte : {BUS_W{1'bz}};
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic txrdy,
  input logic cts_n,
  input logic cs_n,
  input logic rd_n,
  input logic cd,
  input logic tick,
  input logic shift_idle,
  input logic hold_full,
  input logic doe
);
  p_idle_line_r11: assert property (@(posedge clk) disable iff (rst)
    shift_idle |-> txd);

  p_ready_gate_r9: assert property (@(posedge clk) disable iff (rst)
    txrdy |-> (!cts_n && !hold_full));

  p_edge_only_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  p_bus_drive_r3: assert property (@(posedge clk) disable iff (rst)
    doe |-> (!cs_n && !rd_n && cd));

  p_start_cts_r7: assert property (@(posedge clk) disable iff (rst)
    (!shift_idle && $past(shift_idle)) |-> ($past(tick) && !$past(cts_n)));
endmodule

bind async_tx_port atx_checker u_chk (
  .clk(clk), .rst(rst), .txd(txd), .txrdy(txrdy), .cts_n(cts_n),
  .cs_n(cs_n), .rd_n(rd_n), .cd(cd), .tick(tx_tick),
  .shift_idle(shift_idle), .hold_full(hold_full), .doe(bus_oe)
);

// File: tb/async_tx_port_tb.sv
module async_tx_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic txc_n = 1'b1, cts_n = 1'b0, dsr_n = 1'b1;
  logic drv_en = 1'b0;
  logic [7:0] drv_val = 8'h00;
  wire  [7:0] dbus;
  logic txd, txrdy, txempty;
  int checks = 0;
  int errors = 0;

  assign dbus = drv_en ? drv_val : 8'bz;

  always #5 clk = ~clk;

  async_tx_port u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .dbus(dbus), .txc_n(txc_n), .cts_n(cts_n), .dsr_n(dsr_n),
    .txd(txd), .txrdy(txrdy), .txempty(txempty)
  );

  // transmit clock: 16 system clocks per bit
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      txc_n = ~txc_n;
    end
  end

  // format/data pairs; the last one uses the synchronous code and must stay silent
  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hCD55, 16'hCDAA, 16'hFD33, 16'h59A5, 16'h4DC3, 16'h711B, 16'hCC55
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] val);
    @(posedge txc_n);
    @(negedge clk);
    cs_n = 1'b0; cd = sel; drv_val = val; drv_en = 1'b1;
    @(negedge clk) wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; drv_en = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] val);
    @(negedge clk);
    cs_n = 1'b0; cd = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    val = dbus;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic sample_bit(output logic b);
    @(negedge txc_n);
    repeat (5) @(negedge clk);
    b = txd;
  endtask

  // checks one frame; optionally writes a follow-up byte during the start bit
  task automatic expect_frame(input logic [7:0] fmt, input logic [7:0] data,
                              input logic nxt, input logic [7:0] nxt_data,
                              input string tag);
    int len;
    int stops;
    logic [7:0] m;
    logic par;
    logic b;
    len   = 5 + int'(fmt[3:2]);
    stops = (fmt[7:6] == 2'b01) ? 1 : 2;
    m = 8'h00;
    for (int i = 0; i < len; i++) m[i] = data[i];
    par = fmt[5] ? ^m : ~^m;
    sample_bit(b);
    chk({7'b0, b}, 8'h00, {tag, " start bit"});
    if (nxt) begin
      chk({7'b0, txrdy}, 8'h01, "R9 ready after load");
      bus_write(1'b0, nxt_data);
    end
    for (int i = 0; i < len; i++) begin
      sample_bit(b);
      chk({7'b0, b}, {7'b0, data[i]}, {tag, " data bit"});
    end
    if (fmt[4]) begin
      sample_bit(b);
      chk({7'b0, b}, {7'b0, par}, "R6 parity bit");
    end
    for (int i = 0; i < stops; i++) begin
      sample_bit(b);
      chk({7'b0, b}, 8'h01, "R4 stop bit");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [7:0] st;
    logic b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({7'b0, txd}, 8'h01, "R1 txd idle");
    chk({7'b0, txempty}, 8'h01, "R1 txempty");
    chk({7'b0, txrdy}, 8'h00, "R1 txrdy");
    bus_read(st);
    chk(st, 8'h04, "R3 status after reset");

    // table walk: format, enable, data, frame, then soft return to format phase
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] f;
      logic [7:0] d;
      f = VEC[v][15:8];
      d = VEC[v][7:0];
      bus_write(1'b1, f);
      bus_write(1'b1, 8'h11);
      bus_write(1'b0, d);
      if (f[1:0] == 2'b00) begin
        for (int k = 0; k < 3; k++) begin
          sample_bit(b);
          chk({7'b0, b}, 8'h01, "R4 sync code silent");
        end
      end else begin
        expect_frame(f, d, 1'b0, 8'h00, "R5 table");
        sample_bit(b);
        chk({7'b0, b}, 8'h01, "R11 idle after frame");
        chk({7'b0, txempty}, 8'h01, "R9 empty after frame");
      end
      bus_write(1'b1, 8'h40);   // R2 back to format phase
    end

    // directed: status value, command sequencing, CTS hold
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; cts_n = 1'b1; dsr_n = 1'b0;
    bus_write(1'b1, 8'hCD);
    bus_write(1'b1, 8'h11);
    bus_read(st);
    chk(st, 8'h84, "R3 status after setup");
    bus_write(1'b1, 8'h01);   // R2 must be a command, not a format
    bus_write(1'b0, 8'h55);
    for (int k = 0; k < 3; k++) begin
      sample_bit(b);
      chk({7'b0, b}, 8'h01, "R7 held by cts");
    end
    chk({7'b0, txempty}, 8'h00, "R9 empty clear while held");
    chk({7'b0, txrdy}, 8'h00, "R9 not ready while cts high");
    cts_n = 1'b0;
    expect_frame(8'hCD, 8'h55, 1'b0, 8'h00, "R7 after cts low R2");

    // directed: back-to-back frames
    bus_write(1'b0, 8'hAA);
    chk({7'b0, txrdy}, 8'h00, "R9 not ready while holding");
    expect_frame(8'hCD, 8'hAA, 1'b1, 8'h33, "R8 first");
    expect_frame(8'hCD, 8'h33, 1'b0, 8'h00, "R8 no gap");
    sample_bit(b);
    chk({7'b0, b}, 8'h01, "R11 idle");

    // directed: transmitter disabled
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h66);
    for (int k = 0; k < 3; k++) begin
      sample_bit(b);
      chk({7'b0, b}, 8'h01, "R10 disabled holds");
    end
    chk({7'b0, txrdy}, 8'h00, "R10 not ready when disabled");
    bus_write(1'b1, 8'h01);
    expect_frame(8'hCD, 8'h66, 1'b0, 8'h00, "R10 after enable");

    finish_sim();
  end
endmodule